// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Status Flags

This block is a first-in first-out buffer whose write side and read side run on separate, unrelated clocks. A word is stored on each write-clock edge where the active-low write enable is low and the buffer has room. A word is moved into a registered data output on each read-clock edge where the active-low read enable is low and the buffer holds data. Depth is a power of two set by a parameter. The default is 256 words of 18 bits.

Five active-low status outputs describe the fill level: empty, almost empty, half full, almost full and full. The two almost thresholds come from offset inputs that an offset register block elsewhere in the chip drives. Empty and almost empty are registered on the read clock. Full, almost full and half full are registered on the write clock. Each side compares its own pointer against a Gray-coded copy of the other side's pointer that has passed through a multi-stage synchroniser.

A rewind strobe, sampled on the read clock, sends the read pointer back to storage location zero. Data written since reset can then be replayed.

Top module: `pflag_fifo`

## Requirements
- R1: While `rst_n` is low, `empty_n` and `aempty_n` are 0, `full_n`, `afull_n` and `half_n` are 1, and `rd_data` is 0.
- R2: Words leave in the order they were accepted. `rd_data` takes the next word at the `rd_clk` edge where `rd_en_n` is 0, `empty_n` is 1 and `rewind` is 0.
- R3: `full_n` goes to 0 when the write-side count reaches the depth. A write presented while `full_n` is 0 is discarded and never shows up at the output.
- R4: `empty_n` is 0 when the read-side count is zero. A read presented while `empty_n` is 0 is ignored, and `rd_data` keeps the last word that was validly read.
- R5: After a write into an empty buffer, `empty_n` stays 0 at the first `rd_clk` edge that follows the write edge. It rises at the third such edge, with the default of two synchroniser stages. `rd_data` does not change until a read is accepted after that.
- R6: `aempty_n` is 0 while the read-side count is less than or equal to `ae_offset`, and 1 above it. It is updated on `rd_clk`.
- R7: `afull_n` is 0 while the write-side count is at least depth minus `af_offset`, and 1 below that. It is updated on `wr_clk`.
- R8: `half_n` is 0 while the write-side count is greater than half the depth (129 or more words at depth 256), and 1 otherwise. It is updated on `wr_clk`.
- R9: When `rewind` is 1 at an `rd_clk` edge, the read pointer returns to location 0 and any read in that cycle is ignored, so `rd_data` is unchanged. Later reads replay, in order, every word written since reset. This holds when no more than depth words have been written since reset and writes are idle around the strobe.
- R10: At the `rd_clk` edge that applies `rewind`, `empty_n` and `aempty_n` are recomputed from the new distance between the pointers. This is the count of words written since reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst_n | input | 1 | Asynchronous active-low reset for both sides |
| wr_en_n | input | 1 | Active-low write request |
| wr_data | input | DATA_W | Word to store |
| rd_en_n | input | 1 | Active-low read request |
| rewind | input | 1 | Returns the read pointer to location 0 (read domain) |
| rd_data | output | DATA_W | Registered output word |
| ae_offset | input | ADDR_W | Almost-empty threshold |
| af_offset | input | ADDR_W | Almost-full threshold |
| empty_n | output | 1 | Low when empty (read clock) |
| aempty_n | output | 1 | Low when at or below `ae_offset` words (read clock) |
| half_n | output | 1 | Low when above half depth (write clock) |
| afull_n | output | 1 | Low when within `af_offset` of full (write clock) |
| full_n | output | 1 | Low when full (write clock) |

## Verification
A flag that depends only on its own side's pointer is due at the very edge that moves that pointer. The bench therefore samples full, almost full and half full at the write-clock falling edge right after each write. It samples empty and almost empty at the read-clock falling edge right after each read or rewind. Any change that must cross domains is due at the third edge of the destination clock. The bench checks that empty is still asserted at the first read falling edge after a write and released by the fourth. Before each threshold sweep it waits enough idle cycles for the far pointer to settle. The output word is due one read edge after an accepted read. The scoreboard monitor compares it two nanoseconds after that rising edge, on an odd time grid that never meets a write edge.

// File: rtl/pflag_fifo_pkg.sv
package pflag_fifo_pkg;

  localparam int unsigned WORD_BITS = 32;

  typedef struct packed {
    logic full_n;
    logic afull_n;
    logic half_n;
  } wr_flags_t;

  typedef struct packed {
    logic empty_n;
    logic aempty_n;
  } rd_flags_t;

  // binary to reflected Gray code
  function automatic logic [WORD_BITS-1:0] to_gray(input logic [WORD_BITS-1:0] b);
    return b ^ (b >> 1);
  endfunction

  // Gray back to binary: prefix XOR from the top bit down, by doubling shifts
  function automatic logic [WORD_BITS-1:0] from_gray(input logic [WORD_BITS-1:0] g);
    logic [WORD_BITS-1:0] b;
    b = g;
    for (int s = 1; s < int'(WORD_BITS); s = s * 2) b = b ^ (b >> s);
    return b;
  endfunction

  // write-side flags from the occupancy seen by the writer
  function automatic wr_flags_t wr_flags_of(input logic [WORD_BITS-1:0] level,
                                            input logic [WORD_BITS-1:0] depth,
                                            input logic [WORD_BITS-1:0] af_off);
    wr_flags_t f;
    f.full_n  = (level != depth);
    f.afull_n = ((level + af_off) < depth);
    f.half_n  = (level <= (depth >> 1));
    return f;
  endfunction

  // read-side flags from the occupancy seen by the reader
  function automatic rd_flags_t rd_flags_of(input logic [WORD_BITS-1:0] level,
                                            input logic [WORD_BITS-1:0] ae_off);
    rd_flags_t f;
    f.empty_n  = (level != '0);
    f.aempty_n = (level > ae_off);
    return f;
  endfunction

endpackage

// File: rtl/pflag_fifo_sync.sv
module pflag_fifo_sync #(
  parameter int W      = 9,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [STAGES-1:0][W-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/pflag_fifo_wr_ctl.sv
module pflag_fifo_wr_ctl #(
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              wr_clk,
  input  logic              rst_n,
  input  logic              wr_en_n,
  input  logic [ADDR_W-1:0] af_offset,
  input  logic [ADDR_W:0]   rgray_far,
  output logic [ADDR_W:0]   wgray,
  output logic [ADDR_W-1:0] waddr,
  output logic              wr_fire,
  output logic              full_n,
  output logic              afull_n,
  output logic              half_n
);
  import pflag_fifo_pkg::*;

  localparam int PW    = ADDR_W + 1;
  localparam int DEPTH = 1 << ADDR_W;

  logic [PW-1:0] wbin, wbin_nxt, rgray_s, rbin_s, level_nxt;
  wr_flags_t     flags_q, flags_d;

  pflag_fifo_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_rsync (
    .clk(wr_clk), .rst_n(rst_n), .d(rgray_far), .q(rgray_s)
  );

  assign rbin_s    = PW'(from_gray(WORD_BITS'(rgray_s)));
  assign wr_fire   = !wr_en_n && flags_q.full_n;
  assign wbin_nxt  = wbin + PW'(wr_fire);
  assign level_nxt = wbin_nxt - rbin_s;
  assign flags_d   = wr_flags_of(WORD_BITS'(level_nxt), WORD_BITS'(DEPTH),
                                 WORD_BITS'(af_offset));

  always_ff @(posedge wr_clk or negedge rst_n) begin
    if (!rst_n) begin
      wbin    <= '0;
      wgray   <= '0;
      flags_q <= '{full_n: 1'b1, afull_n: 1'b1, half_n: 1'b1};
    end else begin
      wbin    <= wbin_nxt;
      wgray   <= PW'(to_gray(WORD_BITS'(wbin_nxt)));
      flags_q <= flags_d;
    end
  end

  assign waddr   = wbin[ADDR_W-1:0];
  assign full_n  = flags_q.full_n;
  assign afull_n = flags_q.afull_n;
  assign half_n  = flags_q.half_n;

  // R3: a full buffer does not advance the write pointer
  assert_no_overflow_R3: assert property (@(posedge wr_clk) disable iff (!rst_n)
    !full_n |=> $stable(wbin));

  // R7: full always implies almost full
  assert_full_in_afull_R7: assert property (@(posedge wr_clk) disable iff (!rst_n)
    !full_n |-> !afull_n);

  // R8: full always implies half full
  assert_full_in_half_R8: assert property (@(posedge wr_clk) disable iff (!rst_n)
    !full_n |-> !half_n);

endmodule

// File: rtl/pflag_fifo_rd_ctl.sv
module pflag_fifo_rd_ctl #(
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              rd_clk,
  input  logic              rst_n,
  input  logic              rd_en_n,
  input  logic              rewind,
  input  logic [ADDR_W-1:0] ae_offset,
  input  logic [ADDR_W:0]   wgray_far,
  output logic [ADDR_W:0]   rgray,
  output logic [ADDR_W-1:0] raddr,
  output logic              rd_fire,
  output logic              empty_n,
  output logic              aempty_n
);
  import pflag_fifo_pkg::*;

  localparam int PW = ADDR_W + 1;

  logic [PW-1:0] rbin, rbin_nxt, wgray_s, wbin_s, level_nxt;
  rd_flags_t     flags_q, flags_d;

  pflag_fifo_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_wsync (
    .clk(rd_clk), .rst_n(rst_n), .d(wgray_far), .q(wgray_s)
  );

  assign wbin_s    = PW'(from_gray(WORD_BITS'(wgray_s)));
  assign rd_fire   = !rd_en_n && flags_q.empty_n && !rewind;
  assign rbin_nxt  = rewind ? '0 : rbin + PW'(rd_fire);
  assign level_nxt = wbin_s - rbin_nxt;
  assign flags_d   = rd_flags_of(WORD_BITS'(level_nxt), WORD_BITS'(ae_offset));

  always_ff @(posedge rd_clk or negedge rst_n) begin
    if (!rst_n) begin
      rbin    <= '0;
      rgray   <= '0;
      flags_q <= '{empty_n: 1'b0, aempty_n: 1'b0};
    end else begin
      rbin    <= rbin_nxt;
      rgray   <= PW'(to_gray(WORD_BITS'(rbin_nxt)));
      flags_q <= flags_d;
    end
  end

  assign raddr    = rbin[ADDR_W-1:0];
  assign empty_n  = flags_q.empty_n;
  assign aempty_n = flags_q.aempty_n;

  // R4: an empty buffer does not advance the read pointer
  assert_no_underflow_R4: assert property (@(posedge rd_clk) disable iff (!rst_n)
    (!empty_n && !rewind) |=> $stable(rbin));

  // R6: empty always implies almost empty
  assert_empty_in_aempty_R6: assert property (@(posedge rd_clk) disable iff (!rst_n)
    !empty_n |-> !aempty_n);

  // R9: the rewind strobe lands the read pointer on location zero
  assert_rewind_to_zero_R9: assert property (@(posedge rd_clk) disable iff (!rst_n)
    rewind |=> (rbin == '0));

endmodule

// File: rtl/pflag_fifo_ram.sv
module pflag_fifo_ram #(
  parameter int DATA_W = 18,
  parameter int ADDR_W = 8
) (
  input  logic              wr_clk,
  input  logic              wr_fire,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rd_clk,
  input  logic              rst_n,
  input  logic              rd_fire,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge wr_clk) begin
    if (wr_fire) cells[waddr] <= wdata;
  end

  always_ff @(posedge rd_clk or negedge rst_n) begin
    if (!rst_n)       rdata <= '0;
    else if (rd_fire) rdata <= cells[raddr];
  end

endmodule

// File: rtl/pflag_fifo.sv
module pflag_fifo #(
  parameter int DATA_W      = 18,
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              wr_clk,
  input  logic              rd_clk,
  input  logic              rst_n,
  input  logic              wr_en_n,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en_n,
  input  logic              rewind,
  output logic [DATA_W-1:0] rd_data,
  input  logic [ADDR_W-1:0] ae_offset,
  input  logic [ADDR_W-1:0] af_offset,
  output logic              empty_n,
  output logic              aempty_n,
  output logic              half_n,
  output logic              afull_n,
  output logic              full_n
);

  localparam int PW = ADDR_W + 1;

  logic [PW-1:0]     wgray, rgray;
  logic [ADDR_W-1:0] waddr, raddr;
  logic              wr_fire, rd_fire;

  pflag_fifo_wr_ctl #(.ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES)) u_wr (
    .wr_clk(wr_clk), .rst_n(rst_n), .wr_en_n(wr_en_n), .af_offset(af_offset),
    .rgray_far(rgray), .wgray(wgray), .waddr(waddr), .wr_fire(wr_fire),
    .full_n(full_n), .afull_n(afull_n), .half_n(half_n)
  );

  pflag_fifo_rd_ctl #(.ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES)) u_rd (
    .rd_clk(rd_clk), .rst_n(rst_n), .rd_en_n(rd_en_n), .rewind(rewind),
    .ae_offset(ae_offset), .wgray_far(wgray), .rgray(rgray), .raddr(raddr),
    .rd_fire(rd_fire), .empty_n(empty_n), .aempty_n(aempty_n)
  );

  pflag_fifo_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
    .wr_clk(wr_clk), .wr_fire(wr_fire), .waddr(waddr), .wdata(wr_data),
    .rd_clk(rd_clk), .rst_n(rst_n), .rd_fire(rd_fire), .raddr(raddr),
    .rdata(rd_data)
  );

  // R4: the output word holds while nothing may be read
  assert_hold_output_R4: assert property (@(posedge rd_clk) disable iff (!rst_n)
    (!empty_n && !rewind) |=> $stable(rd_data));

  // R9: the rewind cycle never loads a new output word
  assert_rewind_no_load_R9: assert property (@(posedge rd_clk) disable iff (!rst_n)
    rewind |=> $stable(rd_data));

endmodule

// File: tb/test_pflag_fifo.sv
module test_pflag_fifo;

  localparam int DW = 18;
  localparam int AW = 8;
  localparam int DEPTH = 1 << AW;

  logic          wr_clk, rd_clk, rst_n;
  logic          wr_en_n, rd_en_n, rewind;
  logic [DW-1:0] wr_data, rd_data;
  logic [AW-1:0] ae_offset, af_offset;
  logic          empty_n, aempty_n, half_n, afull_n, full_n;

  int total = 0;
  int bad = 0;
  bit done = 0;
  bit pend = 0;
  logic [DW-1:0] sb_q[$];
  logic [DW-1:0] hist[$];
  logic [DW-1:0] last_rd;

  pflag_fifo #(.DATA_W(DW), .ADDR_W(AW)) i_pflag_fifo (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n),
    .wr_en_n(wr_en_n), .wr_data(wr_data), .rd_en_n(rd_en_n), .rewind(rewind),
    .rd_data(rd_data), .ae_offset(ae_offset), .af_offset(af_offset),
    .empty_n(empty_n), .aempty_n(aempty_n), .half_n(half_n),
    .afull_n(afull_n), .full_n(full_n)
  );

  // 50 MHz write clock; read clock of 26 ns on an odd time grid
  initial begin
    wr_clk = 0;
    forever #10 wr_clk = ~wr_clk;
  end
  initial begin
    rd_clk = 0;
    #3;
    forever begin rd_clk = 1; #13; rd_clk = 0; #13; end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // called at a write falling edge; returns at the next one
  task automatic wr_word(input logic [DW-1:0] d);
    wr_data = d;
    wr_en_n = 0;
    if (full_n) begin sb_q.push_back(d); hist.push_back(d); end
    @(posedge wr_clk);
    @(negedge wr_clk);
    wr_en_n = 1;
  endtask

  // called at a read falling edge; returns at the next one
  task automatic rd_word();
    rd_en_n = 0;
    if (empty_n && !rewind) pend = 1;
    @(posedge rd_clk);
    @(negedge rd_clk);
    rd_en_n = 1;
  endtask

  task automatic rd_rewind();
    rd_en_n = 0;
    rewind = 1;
    sb_q = hist;
    @(posedge rd_clk);
    @(negedge rd_clk);
    rewind = 0;
    rd_en_n = 1;
  endtask

  // scoreboard monitor: the word is due one read edge after acceptance
  always @(posedge rd_clk) begin
    if (pend) begin
      logic [DW-1:0] e;
      pend = 0;
      #2;
      if (sb_q.size() == 0) begin
        chk("R2 unexpected word", 32'(rd_data), 32'hDEAD);
      end else begin
        e = sb_q.pop_front();
        chk("R2 order", 32'(rd_data), 32'(e));
        last_rd = e;
      end
    end
  end

  task automatic chk_reset_state();
    chk("R1 empty_n", 32'(empty_n), 0);
    chk("R1 aempty_n", 32'(aempty_n), 0);
    chk("R1 full_n", 32'(full_n), 1);
    chk("R1 afull_n", 32'(afull_n), 1);
    chk("R1 half_n", 32'(half_n), 1);
    chk("R1 rd_data", 32'(rd_data), 0);
  endtask

  initial begin
    repeat (150000) @(posedge wr_clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: run did not complete");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; wr_en_n = 1; rd_en_n = 1; rewind = 0; wr_data = '0;
    ae_offset = 8'd4; af_offset = 8'd3; last_rd = '0;
    #60;
    chk_reset_state();
    #35 rst_n = 1;

    // R4: read while empty is ignored
    @(negedge rd_clk);
    rd_word();
    chk("R4 empty read ignored", 32'(rd_data), 0);
    chk("R4 still empty", 32'(empty_n), 0);

    // R5: empty release latency after one write
    @(negedge wr_clk);
    wr_word(18'h1A5);
    @(negedge rd_clk);
    chk("R5 empty held at first edge", 32'(empty_n), 0);
    repeat (3) @(negedge rd_clk);
    chk("R5 empty released", 32'(empty_n), 1);
    chk("R5 output not early", 32'(rd_data), 0);
    chk("R6 one word is almost empty", 32'(aempty_n), 0);
    rd_word();
    #1;
    chk("R4 empty after last word", 32'(empty_n), 0);
    rd_word();
    chk("R4 output holds last word", 32'(rd_data), 32'h1A5);

    // R6: almost-empty threshold on reads
    @(negedge wr_clk);
    for (int i = 0; i < 10; i++) wr_word(18'(18'h100 + i));
    repeat (6) @(negedge rd_clk);
    chk("R6 ten words above offset", 32'(aempty_n), 1);
    for (int i = 0; i < 5; i++) rd_word();
    chk("R6 five words above offset", 32'(aempty_n), 1);
    rd_word();
    chk("R6 four words at offset", 32'(aempty_n), 0);
    for (int i = 0; i < 4; i++) rd_word();
    chk("R4 drained", 32'(empty_n), 0);

    // R3, R7, R8: fill to the top
    repeat (10) @(negedge wr_clk);
    for (int i = 1; i <= DEPTH; i++) begin
      wr_word(18'(18'h2000 + i));
      if (i == DEPTH / 2)     chk("R8 half not yet", 32'(half_n), 1);
      if (i == DEPTH / 2 + 1) chk("R8 half asserted", 32'(half_n), 0);
      if (i == DEPTH - 4)     chk("R7 afull not yet", 32'(afull_n), 1);
      if (i == DEPTH - 3)     chk("R7 afull asserted", 32'(afull_n), 0);
      if (i == DEPTH - 1)     chk("R3 full not yet", 32'(full_n), 1);
      if (i == DEPTH)         chk("R3 full asserted", 32'(full_n), 0);
    end
    for (int i = 0; i < 3; i++) wr_word(18'h3FFFF);
    chk("R3 full held", 32'(full_n), 0);
    repeat (6) @(negedge rd_clk);
    for (int i = 0; i < DEPTH; i++) rd_word();
    chk("R3 extra writes discarded", 32'(empty_n), 0);
    chk("R3 scoreboard empty", 32'(sb_q.size()), 0);
    repeat (8) @(negedge wr_clk);
    chk("R8 half released", 32'(half_n), 1);
    chk("R7 afull released", 32'(afull_n), 1);
    chk("R3 full released", 32'(full_n), 1);

    // R1 again, then R9 and R10
    @(negedge wr_clk);
    rst_n = 0;
    sb_q.delete();
    hist.delete();
    #7;
    chk_reset_state();
    #30 rst_n = 1;
    @(negedge wr_clk);
    for (int i = 0; i < 5; i++) wr_word(18'(18'h0A0 + i));
    repeat (6) @(negedge rd_clk);
    for (int i = 0; i < 3; i++) rd_word();
    chk("R6 two words left", 32'(aempty_n), 0);
    rd_rewind();
    chk("R9 rewind read ignored", 32'(rd_data), 32'h0A2);
    chk("R10 data to replay", 32'(empty_n), 1);
    chk("R10 five words above offset", 32'(aempty_n), 1);
    for (int i = 0; i < 5; i++) rd_word();
    chk("R9 replay exhausted", 32'(empty_n), 0);
    chk("R9 all replayed", 32'(sb_q.size()), 0);
    chk("R9 last replayed word", 32'(rd_data), 32'h0A4);

    repeat (4) @(negedge rd_clk);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule